// File: doc/BRIEF.md
# Serial Flash Bulk-Erase Command Front End

This block is the command front end of a serial flash device, cut down to the whole-array erase path. It behaves as an SPI mode 0 slave with four pins: an active-low select, a serial clock, a data input and a data output. The three SPI pins are resampled into the system clock domain. Opcodes are shifted in most significant bit first on rising serial clock edges. Three of them are decoded:

- 06h arms a write latch.
- 05h streams the status byte back to the host.
- C7h requests an erase of the whole internal array.

All other opcodes are dropped.

An erase request is taken only when all three conditions hold: the write latch is armed, both protection bits are clear, and select is released exactly after the eighth opcode bit. The erase then runs by itself for a fixed number of system clocks. During that time only the status read is served. At the end a one-cycle strobe sets every byte of the array to FFh. A small read port lets the surrounding logic, or a bench, inspect the array contents.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the status byte is 00h (with the protection parameter at zero) and `sdo` is 0. Array byte i holds i XOR 5Ah.
- R2: Opcode 06h, once its eighth bit is sampled while no erase runs, sets the write latch (status bit 1).
- R3: Opcode 05h drives the status byte out on `sdo`, most significant bit first. A new bit appears on each falling serial clock edge, starting with the falling edge of the eighth opcode bit. The byte repeats until select goes high. With select high, `sdo` is 0.
- R4: Opcode C7h with the latch set and both protection bits clear starts an erase when select rises directly after the eighth bit. Status bit 0 then reads 1 and bit 1 reads 0.
- R5: A C7h frame released after fewer or more than eight bits starts nothing and leaves status and array unchanged.
- R6: A C7h frame with the write latch clear is ignored.
- R7: A C7h frame with either protection bit set is ignored, and the write latch stays set.
- R8: The busy bit stays 1 for exactly ERASE_CYCLES system clocks. `erase_strobe` pulses for one cycle as the busy bit clears, which is ERASE_CYCLES+3 clocks after select is driven high.
- R9: After an erase, every array byte reads FFh.
- R10: While an erase runs, 06h and C7h have no effect, 05h still reports the busy bit, and the write latch reads 0.
- R11: Opcodes other than 06h, 05h and C7h change no state.
- R12: A high `prot_we` loads `prot_in` into the protection bits. `prot_in[0]` maps to status bit 2 and `prot_in[1]` to bit 3. Status bits 7..4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | SPI select, active low |
| sclk | input | 1 | SPI serial clock, idles low |
| sdi | input | 1 | SPI serial data into the block |
| sdo | output | 1 | SPI serial data out of the block |
| prot_we | input | 1 | Load strobe for the protection bits |
| prot_in | input | 2 | New protection bit values |
| mem_addr | input | AW | Array read address |
| mem_data | output | DATA_W | Array byte at `mem_addr` |
| erase_strobe | output | 1 | One-cycle pulse that fills the array with ones |

## Verification
The bench builds the block with ERASE_CYCLES set to 1000 and a 16-byte array. That erase length is long enough for the bench to complete a full status read, an ignored arm command and an ignored erase command while the array is still busy. It is also short enough that many accepted erases fit in one run. The 16-byte array makes checking every byte after each erase cheap. Together these settings put the erase-time command blocking, the exact busy length and the release-point framing all within reach of both the directed and the random sequences.

// File: rtl/fe_pkg.sv
// Package: shared opcodes, status bit positions and the status packer.
// Assumes an 8-bit instruction and an 8-bit status byte.
package fe_pkg;
    typedef enum logic [7:0] {
        OP_ARM  = 8'h06,
        OP_STAT = 8'h05,
        OP_WIPE = 8'hC7
    } fe_op_e;

    localparam int ST_BUSY = 0;
    localparam int ST_LATCH = 1;
    localparam int ST_PROT0 = 2;
    localparam int ST_PROT1 = 3;

    // Assemble the status byte from its live fields.
    function automatic logic [7:0] pack_status(input logic busy, input logic latch,
                                               input logic [1:0] prot);
        logic [7:0] s;
        s = '0;
        s[ST_BUSY] = busy;
        s[ST_LATCH] = latch;
        s[ST_PROT0] = prot[0];
        s[ST_PROT1] = prot[1];
        return s;
    endfunction
endpackage

// File: rtl/fe_sync.sv
// Module: two-flop resynchronizer for a bundle of asynchronous pins.
// Assumes each bit is independent; RST_VAL gives each flop's idle level.
module fe_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the system domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fe_spi_shift.sv
// Module: SPI mode 0 shift engine in the system clock domain.
// Samples data on rising serial clock edges, counts bits in a frame, and
// drives the transmit byte MSB first on falling edges while tx_en is high.
// Assumes synchronized inputs and a serial clock far slower than clk.
module fe_spi_shift #(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_hi,
    input  logic       sclk_s,
    input  logic       sdi_s,
    input  logic       tx_en,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       byte_stb,
    output logic       exact_byte,
    output logic       sdo
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(8);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(7);

    logic             sclk_q;
    logic             sclk_rise;
    logic             sclk_fall;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       tx_idx;

    assign sclk_rise  = sclk_s & ~sclk_q;
    assign sclk_fall  = ~sclk_s & sclk_q;
    assign exact_byte = (cnt == CNT_BYTE);

    // Delayed serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Receive path: shift in, count bits, flag the eighth one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte  <= '0;
            cnt      <= '0;
            byte_stb <= 1'b0;
        end else if (cs_hi) begin
            cnt      <= '0;
            byte_stb <= 1'b0;
        end else begin
            byte_stb <= sclk_rise && (cnt == CNT_LAST);
            if (sclk_rise) begin
                rx_byte <= {rx_byte[6:0], sdi_s};
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end
        end
    end

    // Transmit path: one bit per falling edge, wrapping every byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo    <= 1'b0;
            tx_idx <= '0;
        end else if (cs_hi) begin
            sdo    <= 1'b0;
            tx_idx <= '0;
        end else if (sclk_fall && tx_en) begin
            sdo    <= tx_byte[3'd7 - tx_idx];
            tx_idx <= tx_idx + 1'b1;
        end
    end
endmodule

// File: rtl/fe_array.sv
// Module: small register array that an erase strobe fills with ones.
// Reset loads byte i with i XOR 5Ah so an erase is visible; one read port.
module fe_array #(
    parameter int DEPTH = 16,
    parameter int DW = 8,
    parameter int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam logic [DW-1:0] SEED = DW'(8'h5A);

    logic [DW-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // Per-byte storage: pattern on reset, all ones on erase.
        always_ff @(posedge clk) begin
            if (!rst_n)     mem[g] <= DW'(g) ^ SEED;
            else if (erase) mem[g] <= '1;
        end
    end

    // Read mux with out-of-range addresses returning zero.
    always_comb begin
        rdata = '0;
        if (int'(raddr) < DEPTH) rdata = mem[raddr];
    end
endmodule

// File: rtl/flash_erase_ctrl.sv
// Module: serial flash command front end reduced to the bulk-erase path.
// Decodes arm, status read and erase opcodes, guards erase with the write
// latch, protection bits and exact byte framing, then times the erase.
// Assumes ERASE_CYCLES >= 1 and an SPI clock well below clk / 8.
module flash_erase_ctrl
    import fe_pkg::*;
#(
    parameter int ERASE_CYCLES = 2000,
    parameter int MEM_DEPTH = 16,
    parameter int DATA_W = 8,
    parameter logic [1:0] PROT_INIT = 2'b00,
    localparam int AW = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    input  logic              prot_we,
    input  logic [1:0]        prot_in,
    input  logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              erase_strobe
);
    localparam int TW = $clog2(ERASE_CYCLES + 1);

    logic          cs_hi, sclk_s, sdi_s;
    logic          cs_q, cs_rise;
    logic [7:0]    rx_byte;
    logic          byte_stb, exact_byte;
    logic          busy, latch, rd_mode;
    logic [1:0]    prot;
    logic [TW-1:0] tmr;
    logic [7:0]    status;

    fe_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, sclk, sdi}), .q({cs_hi, sclk_s, sdi_s})
    );

    assign status  = pack_status(busy, latch, prot);
    assign cs_rise = cs_hi & ~cs_q;

    fe_spi_shift #(.CNT_W(4)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sclk_s(sclk_s), .sdi_s(sdi_s),
        .tx_en(rd_mode), .tx_byte(status), .rx_byte(rx_byte),
        .byte_stb(byte_stb), .exact_byte(exact_byte), .sdo(sdo)
    );

    fe_array #(.DEPTH(MEM_DEPTH), .DW(DATA_W), .AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n), .erase(erase_strobe),
        .raddr(mem_addr), .rdata(mem_data)
    );

    // Delayed select for release detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_hi;
    end

    // Status read mode: entered on opcode 05h, left when select rises.
    always_ff @(posedge clk) begin
        if (!rst_n)                              rd_mode <= 1'b0;
        else if (cs_hi)                          rd_mode <= 1'b0;
        else if (byte_stb && rx_byte == OP_STAT) rd_mode <= 1'b1;
    end

    // Protection bits: parameter on reset, test load afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)       prot <= PROT_INIT;
        else if (prot_we) prot <= prot_in;
    end

    // Command decisions and the self-timed erase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            latch        <= 1'b0;
            tmr          <= '0;
            erase_strobe <= 1'b0;
        end else begin
            erase_strobe <= 1'b0;
            if (busy) begin
                if (tmr == '0) begin
                    busy         <= 1'b0;
                    erase_strobe <= 1'b1;
                end else begin
                    tmr <= tmr - 1'b1;
                end
            end else begin
                if (byte_stb && rx_byte == OP_ARM) latch <= 1'b1;
                if (cs_rise && exact_byte && rx_byte == OP_WIPE &&
                    latch && prot == 2'b00) begin
                    busy  <= 1'b1;
                    latch <= 1'b0;
                    tmr   <= TW'(ERASE_CYCLES - 1);
                end
            end
        end
    end
endmodule

// File: rtl/fe_checker.sv
// Module: property checker for the erase front end, bound to the top.
// Uses a local counter for the erase length rather than a deep $past.
module fe_checker #(
    parameter int ERASE_CYCLES = 2000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       latch,
    input logic [1:0] prot,
    input logic       erase_strobe,
    input logic       cs_hi,
    input logic       cs_rise,
    input logic       sdo
);
    int busy_len;

    // Counts consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_strobe |-> busy_len == ERASE_CYCLES);

    // R8
    strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_strobe |-> ($past(busy) && !busy));

    // R4
    start_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(latch) && $past(prot) == 2'b00 && !latch));

    // R5
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    // R10
    busy_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !latch);

    // R3
    idle_sdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi && $past(cs_hi)) |-> !sdo);
endmodule

bind flash_erase_ctrl fe_checker #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .latch(latch), .prot(prot),
    .erase_strobe(erase_strobe), .cs_hi(cs_hi), .cs_rise(cs_rise), .sdo(sdo)
);

// File: tb/flash_erase_ctrl_bench.sv
// Bench: directed corner cases plus seeded random command mix against a model.
module flash_erase_ctrl_bench;
    localparam int N = 1000;
    localparam int DEPTH = 16;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic       sdo;
    logic       prot_we = 1'b0;
    logic [1:0] prot_in = 2'b00;
    logic [3:0] mem_addr = '0;
    logic [7:0] mem_data;
    logic       erase_strobe;

    int n_run = 0, n_fail = 0, strobe_cnt = 0;
    bit m_latch = 0, m_erased = 0;
    bit [1:0] m_prot = 0;
    int m_strobes = 0;

    always #10 clk = ~clk;

    flash_erase_ctrl #(.ERASE_CYCLES(N), .MEM_DEPTH(DEPTH), .DATA_W(8)) u_flash_erase_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .prot_we(prot_we), .prot_in(prot_in), .mem_addr(mem_addr),
        .mem_data(mem_data), .erase_strobe(erase_strobe)
    );

    always @(posedge clk) if (rst_n && erase_strobe) strobe_cnt <= strobe_cnt + 1;

    function automatic logic [7:0] exp_status(bit busy, bit latch, bit [1:0] prot);
        return {4'b0000, prot, latch, busy};
    endfunction

    function automatic logic [7:0] exp_byte(int i, bit erased);
        return erased ? 8'hFF : (8'(i) ^ 8'h5A);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(bit b);
        sdi = b;
        idle(HALF);
        sclk = 1'b1;
        idle(HALF);
        sclk = 1'b0;
    endtask

    // Sends nbits; bits past the eighth are random. Ends with select high.
    task automatic spi_cmd(logic [7:0] op, int nbits);
        cs_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < nbits; i++) spi_bit(i < 8 ? op[7-i] : 1'($urandom));
        idle(HALF);
        cs_n = 1'b1;
    endtask

    task automatic read_status(output logic [7:0] s0, output logic [7:0] s1);
        logic [15:0] r;
        cs_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < 8; i++) spi_bit(i < 8 ? 1'(8'h05 >> (7 - i)) : 1'b0);
        for (int i = 0; i < 16; i++) begin
            idle(HALF);
            r[15-i] = sdo;
            sclk = 1'b1;
            idle(HALF);
            sclk = 1'b0;
        end
        idle(HALF);
        cs_n = 1'b1;
        idle(10);
        s0 = r[15:8];
        s1 = r[7:0];
    endtask

    task automatic check_status(string tag, bit busy);
        logic [7:0] a, b;
        read_status(a, b);
        chk(tag, a, exp_status(busy, m_latch, m_prot));
        chk({tag, " R3 repeat"}, b, a);
    endtask

    task automatic check_mem(string tag);
        for (int i = 0; i < DEPTH; i++) begin
            mem_addr = 4'(i);
            idle(1);
            chk(tag, mem_data, exp_byte(i, m_erased));
        end
    endtask

    task automatic load_prot(bit [1:0] p);
        prot_in = p;
        prot_we = 1'b1;
        idle(1);
        prot_we = 1'b0;
        m_prot = p;
    endtask

    task automatic do_arm(int nbits);
        spi_cmd(8'h06, nbits);
        idle(10);
        if (nbits >= 8) m_latch = 1;
    endtask

    // Erase request; when accepted, measures the strobe delay from select high.
    task automatic do_wipe(int nbits, string tag);
        bit ok;
        int k;
        ok = (nbits == 8) && m_latch && (m_prot == 2'b00);
        spi_cmd(8'hC7, nbits);
        if (ok) begin
            k = 0;
            for (int j = 1; j <= N + 50; j++) begin
                @(posedge clk);
                #1;
                if (erase_strobe) begin
                    k = j;
                    break;
                end
            end
            chk("R8 strobe delay", k, N + 3);
            m_latch = 0;
            m_erased = 1;
            m_strobes++;
            idle(3);
        end else begin
            idle(40);
        end
        chk(tag, strobe_cnt, m_strobes);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] a, b;
        void'($urandom(32'd20240611));
        idle(4);
        rst_n = 1'b1;
        idle(4);

        // R1: reset state
        chk("R1 sdo", sdo, 0);
        check_status("R1 status", 0);
        check_mem("R1 array pattern");

        // R6: erase without the write latch
        do_wipe(8, "R6 no latch");
        check_status("R6 status", 0);

        // R2: arm
        do_arm(8);
        check_status("R2 latch set", 0);

        // R5: bad release points
        do_wipe(7, "R5 short frame");
        do_wipe(9, "R5 long frame");
        check_status("R5 status kept", 0);
        check_mem("R5 array kept");

        // R11: unknown opcode
        spi_cmd(8'hA5, 8);
        idle(10);
        check_status("R11 unknown op", 0);

        // R12 and R7: protection bits block erase
        load_prot(2'b01);
        check_status("R12 prot0", 0);
        do_wipe(8, "R7 prot0 set");
        load_prot(2'b10);
        check_status("R12 prot1", 0);
        do_wipe(8, "R7 prot1 set");
        check_status("R7 latch kept", 0);
        load_prot(2'b00);

        // R4, R8, R9: accepted erase
        do_wipe(8, "R4 accepted");
        check_status("R8 idle after", 0);
        check_mem("R9 all ones");

        // R10: commands during an erase
        do_arm(8);
        spi_cmd(8'hC7, 8);
        idle(4);
        m_latch = 0;
        read_status(a, b);
        chk("R10 busy status", a, exp_status(1, 0, 0));
        chk("R4 latch cleared", b, 8'h01);
        spi_cmd(8'h06, 8);
        idle(10);
        spi_cmd(8'hC7, 8);
        idle(10);
        read_status(a, b);
        chk("R10 arm ignored", a, 8'h01);
        for (int j = 0; j < N + 50 && strobe_cnt < m_strobes + 1; j++) idle(1);
        m_strobes++;
        chk("R10 one strobe", strobe_cnt, m_strobes);
        check_status("R10 after", 0);

        // Random command mix against the model.
        for (int it = 0; it < 40; it++) begin
            int kind;
            kind = int'($urandom % 6);
            case (kind)
                0: do_arm(6 + int'($urandom % 5));
                1: do_wipe(8, "R4 random wipe");
                2: do_wipe(6 + int'($urandom % 5), "R5 random wipe");
                3: begin
                    logic [7:0] op;
                    op = 8'($urandom);
                    if (op == 8'h06 || op == 8'h05 || op == 8'hC7) op = 8'h00;
                    spi_cmd(op, 8);
                    idle(10);
                end
                4: load_prot(($urandom % 3 == 0) ? 2'($urandom) : 2'b00);
                default: ;
            endcase
            if (kind == 0 && m_latch == 0) m_latch = 0;
            check_status("R2 random status", 0);
        end
        check_mem("R9 final array");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule